// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits on the host side of a byte-wide parallel flash. A client gives it one request: an operation code, a target address, a data byte and a start strobe. The block then drives the flash bus with the unlock writes that operation needs, one write per clock. It works out when the flash has finished by reading status back from a fixed address, and ends with a one-clock done pulse. If the flash never reports completion, it ends with a one-clock error pulse instead.

Four operations are supported: byte program, sector erase, whole-chip erase, and enabling the write lock on the boot region. Program completion is judged by comparing the top data bit read back with the top bit that was written. Erase completion is judged by two consecutive reads whose bit 6 agrees. The lock enable needs no polling. After the lock enable the block waits a fixed settle time, set in milliseconds and converted to clocks from the clock frequency parameter.

Top module: `flash_prog_seq`

## Requirements
- R1: Operation code 0 (byte program) issues exactly four writes on consecutive clocks, as address/data pairs: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then request address/request data.
- R2: Operation code 1 (sector erase) issues exactly six consecutive writes: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, then request address/0x30.
- R3: Operation code 2 (chip erase) issues the same first five writes as R2, and the sixth write is 0x5555/0x10.
- R4: Operation code 3 (boot lock enable) issues the first five writes of R2 followed by 0x5555/0x40. It issues no reads, and it raises done exactly PAUSE_CYCLES = CLK_HZ/1000*PAUSE_MS clocks after the cycle of the final write.
- R5: After a program, the block issues polling reads one per clock, all at the request address. The operation completes on the first read whose bit 7 equals bit 7 of the programmed byte.
- R6: After either erase, the block issues polling reads one per clock at the request address. The operation completes on the first read whose bit 6 equals bit 6 of the read just before it.
- R7: If TIMEOUT_POLLS polling reads pass without completion, err pulses, done does not, and the block returns to idle. Completion seen on the last allowed read counts as success.
- R8: A start request is accepted only while busy is low. Requests that arrive while busy is high cause no writes, no reads and no extra done.
- R9: done and err are single-clock pulses that never coincide. busy is high from the clock after acceptance until the clock in which done or err is raised, where busy is already low.
- R10: While reset is high and after it, until the next accepted request, busy, done, err, fl_we, fl_re and fl_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start strobe for a request |
| req_op | input | 2 | Operation: 0 program, 1 sector erase, 2 chip erase, 3 boot lock enable |
| req_addr | input | ADDR_W | Target byte address or sector address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock pulse on successful completion |
| err | output | 1 | One-clock pulse on polling timeout |
| fl_addr | output | ADDR_W | Flash bus address |
| fl_wdata | output | 8 | Flash bus write data |
| fl_we | output | 1 | Flash write strobe, one transaction per clock |
| fl_re | output | 1 | Flash read strobe, one transaction per clock |
| fl_rdata | input | 8 | Flash read data, valid in the clock fl_re is high |

## Verification
The bench builds the block with CLK_HZ = 20000 and PAUSE_MS = 1, which turns the lock settle time into 20 clocks, and with TIMEOUT_POLLS = 16. With these values the exact settle interval can be measured from the last write to done, and the timeout limit can be hit from both sides. A flash that finishes on the sixteenth read succeeds, and a flash that never finishes fails after exactly sixteen reads. A bench flash model that stays busy for a chosen number of reads, with inverted bit 7 or a toggling bit 6, covers both completion rules at zero, small and limit-edge busy lengths.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_LOCK = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_UNLK  = 2'd1,
    ST_POLL  = 2'd2,
    ST_PAUSE = 2'd3
  } st_e;

  localparam logic [14:0] KEY_ADDR_A = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;

  localparam logic [7:0] KEY_DATA_A = 8'hAA;
  localparam logic [7:0] KEY_DATA_B = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_LOCK   = 8'h40;

  localparam int SHORT_LEN = 4;
  localparam int LONG_LEN  = 6;

endpackage

// File: rtl/fseq_unlock_gen.sv
module fseq_unlock_gen
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  op_e               op,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] tgt,
  input  logic [7:0]        din,
  output logic [ADDR_W-1:0] wa,
  output logic [7:0]        wd,
  output logic              last
);

  localparam logic [ADDR_W-1:0] AK_A = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] AK_B = ADDR_W'(KEY_ADDR_B);
  localparam logic [2:0] LAST_SHORT = 3'(SHORT_LEN - 1);
  localparam logic [2:0] LAST_LONG  = 3'(LONG_LEN - 1);

  logic short_seq;
  assign short_seq = (op == OP_PROG);

  always_comb begin
    wa = AK_A;
    wd = KEY_DATA_A;
    case (step)
      3'd0: begin wa = AK_A; wd = KEY_DATA_A; end
      3'd1: begin wa = AK_B; wd = KEY_DATA_B; end
      3'd2: begin wa = AK_A; wd = short_seq ? CMD_PROG : CMD_ERASE; end
      3'd3: begin
        if (short_seq) begin wa = tgt; wd = din; end
        else begin wa = AK_A; wd = KEY_DATA_A; end
      end
      3'd4: begin wa = AK_B; wd = KEY_DATA_B; end
      3'd5: begin
        case (op)
          OP_SECT: begin wa = tgt;  wd = CMD_SECT; end
          OP_CHIP: begin wa = AK_A; wd = CMD_CHIP; end
          default: begin wa = AK_A; wd = CMD_LOCK; end
        endcase
      end
      default: begin wa = AK_A; wd = KEY_DATA_A; end
    endcase
  end

  assign last = short_seq ? (step == LAST_SHORT) : (step == LAST_LONG);

endmodule

// File: rtl/fseq_poll_eval.sv
module fseq_poll_eval #(
  parameter int TIMEOUT_POLLS = 100_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic sample,
  input  logic toggle_mode,
  input  logic exp_b7,
  input  logic rd_b7,
  input  logic rd_b6,
  output logic hit,
  output logic expire
);

  localparam int CW = $clog2(TIMEOUT_POLLS + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_POLLS - 1);

  logic [CW-1:0] cnt;
  logic          prev_b6;
  logic          have_prev;
  logic          match;

  always_comb begin
    if (toggle_mode) match = have_prev && (rd_b6 == prev_b6);
    else             match = (rd_b7 == exp_b7);
  end

  assign hit    = sample && match;
  assign expire = sample && !match && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt       <= '0;
      prev_b6   <= 1'b0;
      have_prev <= 1'b0;
    end else if (sample) begin
      cnt       <= cnt + 1'b1;
      prev_b6   <= rd_b6;
      have_prev <= 1'b1;
    end
  end

  // R7
  poll_limit_chk: assert property (@(posedge clk) disable iff (rst)
    sample |-> (cnt <= CNT_LAST));

endmodule

// File: rtl/fseq_pause_timer.sv
module fseq_pause_timer #(
  parameter int PAUSE_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic fin
);

  localparam int PW = $clog2(PAUSE_CYCLES + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PAUSE_CYCLES - 1);

  logic [PW-1:0] cnt;

  assign fin = run && (cnt == P_LAST);

  always_ff @(posedge clk) begin
    if (rst || start) cnt <= '0;
    else if (run)     cnt <= cnt + 1'b1;
  end

  // R4
  pause_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= P_LAST));

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int CLK_HZ        = 50_000_000,
  parameter int PAUSE_MS      = 1000,
  parameter int TIMEOUT_POLLS = 100_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [7:0]        fl_rdata
);

  localparam int PAUSE_CYCLES = (CLK_HZ / 1000) * PAUSE_MS;

  st_e               state;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [2:0]        step;

  logic [ADDR_W-1:0] u_addr;
  logic [7:0]        u_data;
  logic              u_last;

  logic poll_clear, poll_sample, poll_hit, poll_expire;
  logic pause_start, pause_fin;
  logic unused_rd;

  assign unused_rd = ^fl_rdata[5:0];

  fseq_unlock_gen #(.ADDR_W(ADDR_W)) u_gen (
    .op   (op_q),
    .step (step),
    .tgt  (addr_q),
    .din  (data_q),
    .wa   (u_addr),
    .wd   (u_data),
    .last (u_last)
  );

  assign poll_clear  = (state == ST_UNLK) && u_last && (op_q != OP_LOCK);
  assign poll_sample = (state == ST_POLL) && fl_re;
  assign pause_start = (state == ST_UNLK) && u_last && (op_q == OP_LOCK);

  fseq_poll_eval #(.TIMEOUT_POLLS(TIMEOUT_POLLS)) u_poll (
    .clk         (clk),
    .rst         (rst),
    .clear       (poll_clear),
    .sample      (poll_sample),
    .toggle_mode (op_q != OP_PROG),
    .exp_b7      (data_q[7]),
    .rd_b7       (fl_rdata[7]),
    .rd_b6       (fl_rdata[6]),
    .hit         (poll_hit),
    .expire      (poll_expire)
  );

  fseq_pause_timer #(.PAUSE_CYCLES(PAUSE_CYCLES)) u_pause (
    .clk   (clk),
    .rst   (rst),
    .start (pause_start),
    .run   (state == ST_PAUSE),
    .fin   (pause_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_q     <= OP_PROG;
      addr_q   <= '0;
      data_q   <= '0;
      step     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      fl_addr  <= '0;
      fl_wdata <= '0;
      fl_we    <= 1'b0;
      fl_re    <= 1'b0;
    end else begin
      done  <= 1'b0;
      err   <= 1'b0;
      fl_we <= 1'b0;
      fl_re <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            op_q   <= op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
            step   <= '0;
            busy   <= 1'b1;
            state  <= ST_UNLK;
          end
        end
        ST_UNLK: begin
          fl_we    <= 1'b1;
          fl_addr  <= u_addr;
          fl_wdata <= u_data;
          step     <= step + 3'd1;
          if (u_last) state <= (op_q == OP_LOCK) ? ST_PAUSE : ST_POLL;
        end
        ST_POLL: begin
          if (poll_hit) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else if (poll_expire) begin
            err   <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            fl_re   <= 1'b1;
            fl_addr <= addr_q;
          end
        end
        ST_PAUSE: begin
          if (pause_fin) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R5
  poll_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (fl_re && $past(fl_re)) |-> $stable(fl_addr));

  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re));

  // R8
  accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  // R4
  lock_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAUSE) |-> !fl_re);

endmodule

// File: tb/flash_prog_seq_bench.sv
module flash_prog_seq_bench;

  localparam int AW = 18;
  localparam int TO = 16;
  localparam int PAUSE = 20;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    logic [7:0]    bsy;
    logic          stuck;
    logic          experr;
    logic [7:0]    reads;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{2'd0, 18'h01234, 8'h5A, 8'd0,  1'b0, 1'b0, 8'd1},
    '{2'd0, 18'h3FFFE, 8'hC3, 8'd5,  1'b0, 1'b0, 8'd6},
    '{2'd0, 18'h00010, 8'h80, 8'd15, 1'b0, 1'b0, 8'd16},
    '{2'd0, 18'h20000, 8'h11, 8'd0,  1'b1, 1'b1, 8'd16},
    '{2'd1, 18'h3A000, 8'h00, 8'd0,  1'b0, 1'b0, 8'd2},
    '{2'd1, 18'h38000, 8'h00, 8'd14, 1'b0, 1'b0, 8'd16},
    '{2'd2, 18'h00000, 8'h00, 8'd3,  1'b0, 1'b0, 8'd5},
    '{2'd1, 18'h3C000, 8'h00, 8'd0,  1'b1, 1'b1, 8'd16}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          busy, done, err, fl_we, fl_re;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata;
  logic [7:0]    fl_rdata;

  always #10 clk = ~clk;

  flash_prog_seq #(
    .ADDR_W(AW), .CLK_HZ(20_000), .PAUSE_MS(1), .TIMEOUT_POLLS(TO)
  ) u_flash_prog_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .err(err), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we),
    .fl_re(fl_re), .fl_rdata(fl_rdata)
  );

  // flash model
  logic       m_prog = 1'b1;
  logic [7:0] m_d = 8'h00;
  int         m_busy = 0;
  logic       m_stuck = 1'b0;
  logic       m_tog = 1'b0;

  always_comb begin
    if (m_stuck || m_busy > 0)
      fl_rdata = m_prog ? {~m_d[7], m_tog, 6'h00} : {1'b0, m_tog, 6'h00};
    else
      fl_rdata = m_prog ? m_d : 8'hFF;
  end

  always @(posedge clk) begin
    if (fl_re) begin
      m_tog <= ~m_tog;
      if (!m_stuck && m_busy > 0) m_busy <= m_busy - 1;
    end
  end

  // monitors and counters
  int errors = 0, checks = 0;
  int cyc = 0, wcnt = 0, rcnt = 0, rbad = 0, dcnt = 0, ecnt = 0;
  int last_we = 0, done_cyc = 0, dwide = 0, busy_bad = 0;
  logic prev_done = 1'b0;
  logic [AW-1:0] exp_raddr = '0;
  logic [AW+7:0] wlog [0:15];

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (fl_we) begin
      if (wcnt < 16) wlog[wcnt] = {fl_addr, fl_wdata};
      wcnt++;
      last_we = cyc;
    end
    if (fl_re) begin
      rcnt++;
      if (fl_addr != exp_raddr) rbad++;
    end
    if (done) begin
      dcnt++;
      done_cyc = cyc;
      if (busy) busy_bad++;
    end
    if (done && prev_done) dwide++;
    if (err && busy) busy_bad++;
    prev_done = done;
    if (err) ecnt++;
    if (cyc > 150_000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [AW+7:0] exp_wr(input logic [1:0] op, input int k,
                                           input logic [AW-1:0] a, input logic [7:0] d);
    logic [AW-1:0] ka, kb;
    ka = AW'(15'h5555);
    kb = AW'(15'h2AAA);
    case (k)
      0: return {ka, 8'hAA};
      1: return {kb, 8'h55};
      2: return {ka, (op == 2'd0) ? 8'hA0 : 8'h80};
      3: return (op == 2'd0) ? {a, d} : {ka, 8'hAA};
      4: return {kb, 8'h55};
      default: begin
        if (op == 2'd1) return {a, 8'h30};
        if (op == 2'd2) return {ka, 8'h10};
        return {ka, 8'h40};
      end
    endcase
  endfunction

  task automatic clear_logs();
    wcnt = 0; rcnt = 0; rbad = 0; dcnt = 0; ecnt = 0;
  endtask

  task automatic start_req(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end();
    for (int n = 0; n < 3000 && (dcnt + ecnt) == 0; n++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_writes(input string tag, input logic [1:0] op,
                              input logic [AW-1:0] a, input logic [7:0] d);
    int mism = 0;
    int n = (op == 2'd0) ? 4 : 6;
    chk({tag, " write count"}, wcnt, n);
    for (int k = 0; k < n && k < wcnt; k++)
      if (wlog[k] !== exp_wr(op, k, a, d)) mism++;
    chk({tag, " write contents mismatches"}, mism, 0);
  endtask

  task automatic set_model(input logic prog, input logic [7:0] d, input int b, input logic st);
    m_prog = prog; m_d = d; m_busy = b; m_stuck = st;
    m_tog = ~b[0];
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 busy in reset", busy, 0);
    chk("R10 strobes in reset", {fl_we, fl_re, done, err}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 outputs after reset", {busy, done, err, fl_we, fl_re}, 0);
    chk("R10 address after reset", fl_addr, 0);

    // table walk: R1 R2 R3 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      string wt, rt;
      v = VECS[i];
      wt = (v.op == 2'd0) ? "R1" : (v.op == 2'd1) ? "R2" : "R3";
      rt = v.experr ? "R7" : (v.op == 2'd0) ? "R5" : "R6";
      set_model(v.op == 2'd0, v.data, int'(v.bsy), v.stuck);
      exp_raddr = v.addr;
      clear_logs();
      start_req(v.op, v.addr, v.data);
      wait_end();
      check_writes(wt, v.op, v.addr, v.data);
      chk({rt, " poll read count"}, rcnt, int'(v.reads));
      chk({rt, " poll address mismatches"}, rbad, 0);
      chk({rt, " done pulses"}, dcnt, v.experr ? 0 : 1);
      chk({rt, " err pulses"}, ecnt, v.experr ? 1 : 0);
    end

    // R4: boot lock enable and settle time
    set_model(1'b1, 8'h00, 0, 1'b0);
    clear_logs();
    start_req(2'd3, 18'h3C000, 8'h00);
    wait_end();
    check_writes("R4", 2'd3, 18'h3C000, 8'h00);
    chk("R4 reads during lock", rcnt, 0);
    chk("R4 settle clocks", done_cyc - last_we, PAUSE);
    chk("R4 done pulses", dcnt, 1);

    // R8: requests while busy are ignored
    set_model(1'b1, 8'h3C, 10, 1'b0);
    exp_raddr = 18'h01000;
    clear_logs();
    start_req(2'd0, 18'h01000, 8'h3C);
    repeat (2) @(negedge clk);
    start_req(2'd2, 18'h00000, 8'h00);
    repeat (6) @(negedge clk);
    start_req(2'd1, 18'h38000, 8'h00);
    wait_end();
    chk("R8 writes with busy restarts", wcnt, 4);
    chk("R8 reads with busy restarts", rcnt, 11);
    chk("R8 done pulses", dcnt, 1);
    chk("R8 idle after finish", busy, 0);

    // R9: pulse shape across all runs
    chk("R9 done wider than one clock", dwide, 0);
    chk("R9 busy high at done or err", busy_bad, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule